// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block sits on the host side of a three-wire synchronous serial link to a 16-bit sampling converter. It owns an active-low select line, generates the serial data clock from the system clock, and samples the converter's serial output. Select is held high whenever no frame is running, because a deselected converter sits in its power-down mode.

A frame begins on a start request, or on expiry of a sample-period counter when continuous mode is enabled. The controller drops select, runs a fixed number of data-clock periods (an acquisition window, one null bit and the 16 result bits), captures the result bits on data-clock falling edges, most significant bit first, and then releases select. The assembled unsigned word appears on a parallel output with a one-cycle valid strobe. After each frame, select stays high for a guard interval of at least one data-clock period before another frame may begin.

The data-clock half period, in system clocks, comes from a runtime divide input. It is clamped to a window that keeps the clock inside the converter's legal frequency range, and it is latched at frame start.

Top module: `sar_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, busy_o is 0, valid_o is 0 and data_o is 0.
- R2: A start_i sampled high while idle drives cs_n_o low on the next cycle with sclk_o low. sclk_o then rises H cycles later and toggles every H system cycles, so its period is 2H.
- R3: H is MIN_HALF when div_i is below MIN_HALF, MAX_HALF when div_i is above MAX_HALF, and div_i otherwise. H is latched when the frame starts, and a change of div_i during a frame has no effect on that frame.
- R4: While cs_n_o is low, sclk_o shows exactly FRAME = ACQ_LEN + 1 + DATA_W falling edges (22 by default). cs_n_o rises H cycles after the last falling edge, and sclk_o is low whenever cs_n_o is high.
- R5: sdi_i is captured at falling edges ACQ_LEN+2 through FRAME (7 to 22 by default), the first capture becoming data_o bit DATA_W-1 (MSB first, straight binary). The levels at falling edges 1 to ACQ_LEN+1 (acquisition and null bit) do not reach data_o.
- R6: valid_o is high for exactly one cycle, in the cycle in which cs_n_o has just risen, and data_o holds the result until the next one.
- R7: busy_o is 1 exactly while cs_n_o is 0.
- R8: Between the rise of cs_n_o and its next fall there are at least 2H+1 system cycles.
- R9: start_i has no effect while a frame or its guard interval is running: no extra frame is started.
- R10: With cont_i high, successive falls of cs_n_o are max(period_i, (2·FRAME+3)·H + 1) system cycles apart. With cont_i low, no frame starts without start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame (taken only when idle) |
| cont_i | input | 1 | Continuous mode enable |
| div_i | input | DIV_W | Requested data-clock half period, in system clocks |
| period_i | input | PER_W | Continuous-mode sample period, in system clocks |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select, high means converter shutdown |
| sclk_o | output | 1 | Serial data clock |
| busy_o | output | 1 | High while a frame holds select low |
| data_o | output | DATA_W | Last assembled result |
| valid_o | output | 1 | One-cycle strobe with a new result |

## Verification
The bench builds the controller with DIV_W=6, MIN_HALF=3, MAX_HALF=20 and PER_W=12, keeping the default 16-bit word and five-period acquisition window. The narrow clamp window means divide values of 1 and 63 reach both clamp limits within a frame of a few hundred cycles, while a value of 20 lands exactly on the upper limit. A 12-bit period lets continuous mode be run both above and below the minimum frame spacing, so that both sides of the retrigger maximum can be observed. A converter stub drives ones during acquisition and zero for the null bit, so any misplaced capture window shows up in the data.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_GUARD = 2'd2
  } sar_st_e;
endpackage

// File: rtl/sar_half_div.sv
module sar_half_div #(
  parameter int DIV_W    = 12,
  parameter int MIN_HALF = 21,
  parameter int MAX_HALF = 2083
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] h_eff;
  logic [DIV_W-1:0] h_lat;
  logic [DIV_W-1:0] cnt;

  always_comb begin
    if (div_i < DIV_W'(MIN_HALF))      h_eff = DIV_W'(MIN_HALF);
    else if (div_i > DIV_W'(MAX_HALF)) h_eff = DIV_W'(MAX_HALF);
    else                               h_eff = div_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_lat <= DIV_W'(MIN_HALF);
      cnt   <= '0;
    end else if (restart_i) begin
      h_lat <= h_eff;
      cnt   <= h_eff - DIV_W'(1);
    end else if (run_i) begin
      if (cnt == '0) cnt <= h_lat - DIV_W'(1);
      else           cnt <= cnt - DIV_W'(1);
    end
  end

  assign tick_o = run_i && !restart_i && (cnt == '0);
endmodule

// File: rtl/sar_shift_in.sv
module sar_shift_in #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)       word_o <= '0;
    else if (en_i) word_o <= {word_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/sar_trig.sv
module sar_trig #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [PER_W-1:0] period_i,
  output logic             due_o
);
  logic [PER_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || clear_i)  pcnt <= '0;
    else if (pcnt != '1) pcnt <= pcnt + PER_W'(1);
  end

  assign due_o = ({1'b0, pcnt} + (PER_W+1)'(1)) >= {1'b0, period_i};
endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ACQ_LEN  = 5,
  parameter int DIV_W    = 12,
  parameter int MIN_HALF = 21,
  parameter int MAX_HALF = 2083,
  parameter int PER_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              sdi_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int FRAME = ACQ_LEN + 1 + DATA_W;
  localparam int EW    = $clog2(FRAME + 1);

  sar_st_e           st;
  logic [EW-1:0]     edge_cnt;
  logic              gflag;
  logic              tick;
  logic              due;
  logic              fire;
  logic              cap_en;
  logic [DATA_W-1:0] word;

  assign fire   = (st == ST_IDLE) && (start_i || (cont_i && due));
  assign cap_en = (st == ST_RUN) && tick && sclk_o && (edge_cnt >= EW'(ACQ_LEN + 1));

  sar_half_div #(
    .DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)
  ) u_div (
    .clk(clk), .rst(rst), .run_i(st != ST_IDLE), .restart_i(fire),
    .div_i(div_i), .tick_o(tick)
  );

  sar_shift_in #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .en_i(cap_en), .bit_i(sdi_i), .word_o(word)
  );

  sar_trig #(.PER_W(PER_W)) u_trig (
    .clk(clk), .rst(rst), .clear_i(fire), .period_i(period_i), .due_o(due)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cs_n_o   <= 1'b1;
      sclk_o   <= 1'b0;
      busy_o   <= 1'b0;
      valid_o  <= 1'b0;
      data_o   <= '0;
      edge_cnt <= '0;
      gflag    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (fire) begin
            st       <= ST_RUN;
            cs_n_o   <= 1'b0;
            busy_o   <= 1'b1;
            sclk_o   <= 1'b0;
            edge_cnt <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (!sclk_o && (edge_cnt == EW'(FRAME))) begin
              st      <= ST_GUARD;
              cs_n_o  <= 1'b1;
              busy_o  <= 1'b0;
              valid_o <= 1'b1;
              data_o  <= word;
              gflag   <= 1'b0;
            end else begin
              sclk_o <= ~sclk_o;
              if (sclk_o) edge_cnt <= edge_cnt + EW'(1);
            end
          end
        end
        ST_GUARD: begin
          if (tick) begin
            if (gflag) st <= ST_IDLE;
            else       gflag <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_rd_ctrl_chk.sv
module sar_rd_ctrl_chk #(
  parameter int DATA_W   = 16,
  parameter int ACQ_LEN  = 5,
  parameter int MIN_HALF = 21,
  parameter int MAX_HALF = 2083
) (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o
);
  localparam int FRAME = ACQ_LEN + 1 + DATA_W;

  logic        sclk_q;
  logic [15:0] run_len;
  logic [7:0]  fall_cnt;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_o;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n_o)       run_len <= '0;
    else if (sclk_o != sclk_q) run_len <= 16'd1;
    else if (run_len != '1)  run_len <= run_len + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n_o)            fall_cnt <= '0;
    else if (sclk_q && !sclk_o)   fall_cnt <= fall_cnt + 8'd1;
  end

  p_half_min_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && (sclk_o != sclk_q)) |-> (run_len >= 16'(MIN_HALF)));

  p_half_max_r3: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> (run_len <= 16'(MAX_HALF)));

  p_frame_edges_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (fall_cnt == 8'(FRAME)));

  p_idle_sclk_low_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_valid_release_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(cs_n_o));

  p_busy_select_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o == !cs_n_o);

  p_guard_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |=> cs_n_o);
endmodule

bind sar_rd_ctrl sar_rd_ctrl_chk #(
  .DATA_W(DATA_W), .ACQ_LEN(ACQ_LEN), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)
) u_chk (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .busy_o(busy_o), .valid_o(valid_o)
);

// File: tb/test_sar_rd_ctrl.sv
module test_sar_rd_ctrl;
  localparam int DATA_W = 16;
  localparam int ACQ    = 5;
  localparam int FRAME  = ACQ + 1 + DATA_W;
  localparam int DIV_W  = 6;
  localparam int PER_W  = 12;
  localparam int HMIN   = 3;
  localparam int HMAX   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cont = 1'b0;
  logic [DIV_W-1:0] div_r = 6'd4;
  logic [PER_W-1:0] period_r = 12'd400;
  logic sdi = 1'b1;
  logic cs_n, sclk, busy, valid;
  logic [DATA_W-1:0] data;

  always #2 clk = ~clk;

  sar_rd_ctrl #(
    .DATA_W(DATA_W), .ACQ_LEN(ACQ), .DIV_W(DIV_W),
    .MIN_HALF(HMIN), .MAX_HALF(HMAX), .PER_W(PER_W)
  ) i_sar_rd_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .cont_i(cont), .div_i(div_r),
    .period_i(period_r), .sdi_i(sdi), .cs_n_o(cs_n), .sclk_o(sclk),
    .busy_o(busy), .data_o(data), .valid_o(valid)
  );

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] word_q[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp_h(int d);
    if (d < HMIN) return HMIN;
    if (d > HMAX) return HMAX;
    return d;
  endfunction

  // converter stub: ones during acquisition, zero null bit, then the word MSB first
  logic [DATA_W-1:0] cur_word = '0;
  int stub_cnt = 0;
  always @(negedge cs_n or posedge sclk) begin
    if (!sclk) begin
      stub_cnt = 0;
      cur_word = (word_q.size() != 0) ? word_q.pop_front() : '0;
      sdi <= 1'b1;
    end else if (!cs_n) begin
      stub_cnt = stub_cnt + 1;
      if (stub_cnt >= ACQ + 2 && stub_cnt <= FRAME) sdi <= cur_word[FRAME - stub_cnt];
      else if (stub_cnt == ACQ + 1)                  sdi <= 1'b0;
      else                                           sdi <= 1'b1;
    end
  end

  // monitor / scoreboard
  int exp_h = 4;
  int frame_h = 4;
  int exp_space = 0;
  bit spacing_on = 1'b0;
  bit have_fall = 1'b0;
  bit have_rise = 1'b0;
  int cyc = 0, last_fall = 0, rise_cyc = 0, seg_len = 0, falls = 0;
  bit seg_bad = 1'b0, busy_bad = 1'b0;
  int frames_started = 0, results = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;
  logic [DATA_W-1:0] last_word = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      seg_len++;
      if (prev_cs && !cs_n) begin
        frames_started++;
        if (have_rise) check(cyc - rise_cyc >= 2*frame_h + 1, "R8", "select high time", cyc - rise_cyc, 2*frame_h + 1);
        if (spacing_on && have_fall) check(cyc - last_fall == exp_space, "R10", "retrigger spacing", cyc - last_fall, exp_space);
        last_fall = cyc; have_fall = 1'b1;
        seg_len = 0; seg_bad = 1'b0; busy_bad = 1'b0; falls = 0;
        frame_h = exp_h;
        check(busy == 1'b1, "R7", "busy at select fall", busy, 1);
      end else if (!cs_n) begin
        if (sclk != prev_sclk) begin
          if (seg_len != frame_h) seg_bad = 1'b1;
          seg_len = 0;
          if (prev_sclk && !sclk) falls++;
        end
        if (busy !== 1'b1) busy_bad = 1'b1;
      end
      if (!prev_cs && cs_n) begin
        if (seg_len != frame_h) seg_bad = 1'b1;
        check(!seg_bad, "R3", "all half periods equal latched H", seg_bad, 0);
        check(falls == FRAME, "R4", "falling edges per frame", falls, FRAME);
        check(sclk == 1'b0, "R4", "sclk low at release", sclk, 0);
        check(busy == 1'b0 && !busy_bad, "R7", "busy tracks select", busy, 0);
        rise_cyc = cyc; have_rise = 1'b1;
      end
      if (valid) begin
        check(cs_n && !prev_cs, "R6", "valid with select release", cs_n, 1);
        if (exp_q.size() == 0) check(1'b0, "R5", "unexpected result", data, 0);
        else begin
          automatic logic [DATA_W-1:0] e = exp_q.pop_front();
          check(data == e, "R5", "result word", data, e);
        end
        last_word = data;
        results++;
      end
      if (valid && prev_valid) check(1'b0, "R6", "valid width", 2, 1);
      if (prev_valid && !valid) check(data == last_word, "R6", "data held", data, last_word);
      prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
    end
  end

  task automatic push(logic [DATA_W-1:0] w);
    exp_q.push_back(w);
    word_q.push_back(w);
  endtask

  task automatic do_frame(logic [DATA_W-1:0] w, int d);
    int n;
    n = results;
    div_r = DIV_W'(d);
    exp_h = clamp_h(d);
    push(w);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(cs_n == 1'b0 && sclk == 1'b0, "R2", "select low after start", {cs_n, sclk}, 0);
    wait (results == n + 1);
    repeat (2*exp_h + 2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", wd, 150000);
      finish_run();
    end
  end

  initial begin
    int base, rbase;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
    check(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    check(valid == 1'b0, "R1", "reset valid", valid, 0);
    check(data == '0, "R1", "reset data", data, 0);

    // R2 R5: several words and rates
    do_frame(16'hA5C3, 4);
    do_frame(16'h0000, 5);
    do_frame(16'hFFFF, 3);
    // R3: clamp limits
    do_frame(16'h8001, 1);
    do_frame(16'h1234, 63);
    do_frame(16'h7FFE, 20);

    // R9 and R3 latch: starts during frame and guard, div change mid-frame
    base = frames_started; rbase = results;
    div_r = 6'd4; exp_h = 4;
    push(16'h5AA5);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    div_r = 6'd10;
    repeat (3) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (15) @(negedge clk);
    end
    wait (results == rbase + 1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    check(frames_started == base + 1, "R9", "frames after ignored starts", frames_started - base, 1);
    check(cs_n == 1'b1, "R9", "select idle after ignored starts", cs_n, 1);

    // R10: continuous, period above minimum spacing
    div_r = 6'd4; exp_h = 4;
    period_r = 12'd400; exp_space = 400;
    have_fall = 1'b0; spacing_on = 1'b1;
    repeat (4) push(16'hC0DE);
    base = frames_started; rbase = results;
    @(negedge clk) cont = 1'b1;
    wait (frames_started == base + 4);
    @(negedge clk) cont = 1'b0;
    wait (results == rbase + 4);
    repeat (12) @(negedge clk);

    // R10: period below minimum spacing
    period_r = 12'd50; exp_space = (2*FRAME + 3)*4 + 1;
    have_fall = 1'b0;
    push(16'h0F0F); push(16'hF0F0); push(16'h3C3C);
    base = frames_started; rbase = results;
    @(negedge clk) cont = 1'b1;
    wait (frames_started == base + 3);
    @(negedge clk) cont = 1'b0;
    wait (results == rbase + 3);
    spacing_on = 1'b0;
    repeat (600) @(negedge clk);
    check(frames_started == base + 3, "R10", "no frame with cont low", frames_started - base, 3);
    check(exp_q.size() == 0, "R5", "all results delivered", exp_q.size(), 0);

    finish_run();
  end
endmodule